// File: doc/BRIEF.md
# Shared Address/Data Bus Cycle Sequencer

This block runs a single read or write transfer, to memory or to I/O space, on an external bus whose lower sixteen lines carry first the address and then the data, and whose top four lines carry first the upper address bits and then status. A core presents a request with a direction, a space select, a 20-bit address, a byte or word size, a two-bit segment tag, an interrupt-enable flag and 16 bits of write data. The sequencer then steps through four base clock states. In the first state it places the address on the bus and raises a latch pulse so that an external latch can hold the address. In the middle states it drives the read or write strobe, the transceiver enable and the transceiver direction. In the last state it releases the strobes and reports completion.

A ready input stretches the transfer. While ready is low at the end of the third state, the sequencer repeats that state's outputs as wait states. Read data is taken from the bus on the clock edge that ends the data phase. It is then held on a result port until the next read.

Top module: `muxbus_cycle`

## Requirements
- R1: After reset and while idle, both strobes, the transceiver enable and the high-select pin are high. The latch pulse, busy, done, the bus output enable, the I/O select and the direction pin are low, and rdata is 0.
- R2: A request is taken only while busy is low. The first state (T1) follows on the next clock. A request raised while a transfer runs has no effect: the transfer's outputs are unchanged, and no new transfer starts after it ends.
- R3: In T1 only, the latch pulse is high. The low bus lines are driven with address bits 15..0, and the top lines carry address bits 19..16.
- R4: From T2 to T4 the top lines carry status, with bit 3 = 0, bit 2 = the interrupt-enable flag of the request, and bits 1..0 = the segment tag. The tag codes are 00 extra, 01 stack, 10 code or none, and 11 data.
- R5: In T1 the high-select pin (active low) is low when the request is a word or the address is odd. It is high for a byte at an even address. So with address bit 0 the pair gives 00 word, 01 upper byte, and 10 lower byte. From T2 to T4 the pin shows a status bit that is driven low.
- R6: The I/O select is high for an I/O request and low for a memory request. It holds that value from T1 through T4.
- R7: A read drives the direction pin low from T1 to T4. It drives the read strobe and the transceiver enable low in T2, T3 and every wait state, and it stops driving the low bus lines from T2 onward.
- R8: A write drives the direction pin high from T1 to T4. It drives the write strobe and the transceiver enable low in T2, T3 and every wait state, and it drives the write data on the low bus lines from T2 through T4.
- R9: Each cycle that ready is low at the end of T3 or of a wait state adds one wait state with T3's outputs. The transfer moves to T4 after the first such edge with ready high.
- R10: A read samples the bus input on the edge that ends T3 or the last wait state. The sampled value shows on rdata from T4 and is held through later writes until the next read.
- R11: Done is high for exactly the T4 cycle, with both strobes and the transceiver enable high. The cycle after T4 is idle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| req_valid | input | 1 | Request strobe, taken while idle |
| req_write | input | 1 | 1 = write, 0 = read |
| req_io | input | 1 | 1 = I/O space, 0 = memory |
| req_addr | input | 20 | Transfer address |
| req_word | input | 1 | 1 = word, 0 = byte |
| req_seg | input | 2 | Segment tag shown in status |
| req_ie | input | 1 | Interrupt-enable flag shown in status |
| req_wdata | input | 16 | Write data |
| ready | input | 1 | Low to add wait states |
| bus_ad_in | input | 16 | Value read from the shared low lines |
| bus_ad_out | output | 16 | Value driven on the shared low lines |
| bus_ad_oe | output | 1 | Drive enable for the shared low lines |
| bus_hi | output | 4 | Upper address, then status |
| hi_sel_n | output | 1 | High-byte select, then status |
| addr_strobe | output | 1 | Address latch pulse |
| io_sel | output | 1 | High for I/O, low for memory |
| rd_stb_n | output | 1 | Read strobe, active low |
| wr_stb_n | output | 1 | Write strobe, active low |
| xcvr_en_n | output | 1 | Data transceiver enable, active low |
| xfer_dir | output | 1 | Transceiver direction, high = out |
| busy | output | 1 | Transfer in progress |
| done | output | 1 | One-cycle completion pulse |
| rdata | output | 16 | Last read data |

## Verification
Memory and I/O transfers are run in both directions. This separates the space select from the direction pin and the strobe choice. Byte transfers at even and odd addresses and word transfers at even addresses check the three high-select codes, and all four segment tags with both flag values show that the status nibble is mapped bit by bit. Runs with zero, one and three wait states check that the data phase stretches, and that read data is taken on the edge that ends it and not at the end of T3. A request raised during a transfer checks that it is ignored. A write placed between two reads checks that rdata is held.

// File: rtl/muxbus_pkg.sv
package muxbus_pkg;

    parameter int ADDR_W = 20;
    parameter int DATA_W = 16;
    localparam int HI_W  = ADDR_W - DATA_W;
    parameter int SEG_W  = 2;

    typedef enum logic [2:0] {
        PH_IDLE = 3'd0,
        PH_T1   = 3'd1,
        PH_T2   = 3'd2,
        PH_T3   = 3'd3,
        PH_TW   = 3'd4,
        PH_T4   = 3'd5
    } phase_t;

    typedef struct packed {
        logic              write;
        logic              io;
        logic [ADDR_W-1:0] addr;
        logic              word;
        logic [SEG_W-1:0]  seg;
        logic              ie;
        logic [DATA_W-1:0] wdata;
    } xfer_req_t;

    function automatic logic [HI_W-1:0] status_nibble(input logic ie, input logic [SEG_W-1:0] seg);
        logic [HI_W-1:0] s;
        s = '0;
        s[SEG_W-1:0] = seg;
        s[SEG_W]     = ie;
        return s;
    endfunction

    function automatic logic hi_select_n(input logic word, input logic a0);
        return !(word || a0);
    endfunction

    function automatic logic in_data_phase(input phase_t ph);
        return (ph == PH_T2) || (ph == PH_T3) || (ph == PH_TW);
    endfunction

endpackage

// File: rtl/muxbus_req_latch.sv
module muxbus_req_latch
    import muxbus_pkg::*;
(
    input  logic      clk,
    input  logic      rst,
    input  logic      take,
    input  xfer_req_t req_in,
    output xfer_req_t req_q
);
    always_ff @(posedge clk) begin
        if (rst) begin
            req_q <= '0;
        end else if (take) begin
            req_q <= req_in;
        end
    end
endmodule

// File: rtl/muxbus_phase_fsm.sv
module muxbus_phase_fsm
    import muxbus_pkg::*;
(
    input  logic   clk,
    input  logic   rst,
    input  logic   req_valid,
    input  logic   ready,
    output phase_t phase,
    output logic   take,
    output logic   data_end
);
    phase_t phase_nxt;

    assign take     = (phase == PH_IDLE) && req_valid;
    assign data_end = ((phase == PH_T3) || (phase == PH_TW)) && ready;

    always_comb begin
        phase_nxt = phase;
        unique case (phase)
            PH_IDLE: if (req_valid) phase_nxt = PH_T1;
            PH_T1:   phase_nxt = PH_T2;
            PH_T2:   phase_nxt = PH_T3;
            PH_T3,
            PH_TW:   phase_nxt = ready ? PH_T4 : PH_TW;
            PH_T4:   phase_nxt = PH_IDLE;
            default: phase_nxt = PH_IDLE;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) phase <= PH_IDLE;
        else     phase <= phase_nxt;
    end

    // R2
    accept_to_t1_chk: assert property (@(posedge clk) disable iff (rst)
        take |=> (phase == PH_T1));

    // R2
    busy_req_ignored_chk: assert property (@(posedge clk) disable iff (rst)
        (phase == PH_T4) |=> (phase == PH_IDLE));

    // R9
    wait_insert_chk: assert property (@(posedge clk) disable iff (rst)
        ((phase == PH_T3) || (phase == PH_TW)) && !ready |=> (phase == PH_TW));
endmodule

// File: rtl/muxbus_pin_drive.sv
module muxbus_pin_drive
    import muxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  phase_t            phase,
    input  xfer_req_t         req_q,
    input  logic              data_end,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic [HI_W-1:0]   bus_hi,
    output logic              hi_sel_n,
    output logic              addr_strobe,
    output logic              io_sel,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic              xcvr_en_n,
    output logic              xfer_dir,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    logic in_cyc, is_t1, dph, wr_tail;

    assign in_cyc  = (phase != PH_IDLE);
    assign is_t1   = (phase == PH_T1);
    assign dph     = in_data_phase(phase);
    assign wr_tail = req_q.write && (dph || (phase == PH_T4));

    always_comb begin
        bus_ad_out  = '0;
        bus_hi      = '0;
        hi_sel_n    = 1'b1;
        if (is_t1) begin
            bus_ad_out = req_q.addr[DATA_W-1:0];
            bus_hi     = req_q.addr[ADDR_W-1:DATA_W];
            hi_sel_n   = hi_select_n(req_q.word, req_q.addr[0]);
        end else if (in_cyc) begin
            bus_hi     = status_nibble(req_q.ie, req_q.seg);
            hi_sel_n   = 1'b0;
            if (req_q.write) bus_ad_out = req_q.wdata;
        end
    end

    assign bus_ad_oe   = is_t1 || wr_tail;
    assign addr_strobe = is_t1;
    assign io_sel      = in_cyc && req_q.io;
    assign xfer_dir    = in_cyc && req_q.write;
    assign rd_stb_n    = !(dph && !req_q.write);
    assign wr_stb_n    = !(dph && req_q.write);
    assign xcvr_en_n   = !dph;
    assign busy        = in_cyc;
    assign done        = (phase == PH_T4);

    always_ff @(posedge clk) begin
        if (rst) begin
            rdata <= '0;
        end else if (data_end && !req_q.write) begin
            rdata <= bus_ad_in;
        end
    end

    // R7
    strobe_exclusive_chk: assert property (@(posedge clk) disable iff (rst)
        !(!rd_stb_n && !wr_stb_n));

    // R3
    latch_single_chk: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |=> !addr_strobe);

    // R5
    s7_low_chk: assert property (@(posedge clk) disable iff (rst)
        addr_strobe |=> !hi_sel_n);

    // R11
    done_quiet_chk: assert property (@(posedge clk) disable iff (rst)
        done |-> (rd_stb_n && wr_stb_n && xcvr_en_n));

    // R11
    done_pulse_chk: assert property (@(posedge clk) disable iff (rst)
        done |=> !done && !busy);
endmodule

// File: rtl/muxbus_cycle.sv
module muxbus_cycle
    import muxbus_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              req_valid,
    input  logic              req_write,
    input  logic              req_io,
    input  logic [ADDR_W-1:0] req_addr,
    input  logic              req_word,
    input  logic [SEG_W-1:0]  req_seg,
    input  logic              req_ie,
    input  logic [DATA_W-1:0] req_wdata,
    input  logic              ready,
    input  logic [DATA_W-1:0] bus_ad_in,
    output logic [DATA_W-1:0] bus_ad_out,
    output logic              bus_ad_oe,
    output logic [HI_W-1:0]   bus_hi,
    output logic              hi_sel_n,
    output logic              addr_strobe,
    output logic              io_sel,
    output logic              rd_stb_n,
    output logic              wr_stb_n,
    output logic              xcvr_en_n,
    output logic              xfer_dir,
    output logic              busy,
    output logic              done,
    output logic [DATA_W-1:0] rdata
);
    xfer_req_t req_in, req_q;
    phase_t    phase;
    logic      take, data_end;

    always_comb begin
        req_in.write = req_write;
        req_in.io    = req_io;
        req_in.addr  = req_addr;
        req_in.word  = req_word;
        req_in.seg   = req_seg;
        req_in.ie    = req_ie;
        req_in.wdata = req_wdata;
    end

    muxbus_phase_fsm u_fsm (
        .clk(clk), .rst(rst), .req_valid(req_valid), .ready(ready),
        .phase(phase), .take(take), .data_end(data_end)
    );

    muxbus_req_latch u_latch (
        .clk(clk), .rst(rst), .take(take), .req_in(req_in), .req_q(req_q)
    );

    muxbus_pin_drive u_pins (
        .clk(clk), .rst(rst), .phase(phase), .req_q(req_q), .data_end(data_end),
        .bus_ad_in(bus_ad_in), .bus_ad_out(bus_ad_out), .bus_ad_oe(bus_ad_oe),
        .bus_hi(bus_hi), .hi_sel_n(hi_sel_n), .addr_strobe(addr_strobe),
        .io_sel(io_sel), .rd_stb_n(rd_stb_n), .wr_stb_n(wr_stb_n),
        .xcvr_en_n(xcvr_en_n), .xfer_dir(xfer_dir), .busy(busy),
        .done(done), .rdata(rdata)
    );

    // R6
    io_hold_chk: assert property (@(posedge clk) disable iff (rst)
        busy && !done |=> $stable(io_sel));
endmodule

// File: tb/muxbus_cycle_bench.sv
module muxbus_cycle_bench;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        req_valid = 1'b0, req_write = 1'b0, req_io = 1'b0, req_word = 1'b0, req_ie = 1'b0;
    logic [19:0] req_addr = '0;
    logic [1:0]  req_seg = '0;
    logic [15:0] req_wdata = '0, bus_ad_in = '0;
    logic        ready = 1'b1;
    logic [15:0] bus_ad_out, rdata;
    logic [3:0]  bus_hi;
    logic        bus_ad_oe, hi_sel_n, addr_strobe, io_sel, rd_stb_n, wr_stb_n;
    logic        xcvr_en_n, xfer_dir, busy, done;

    int unsigned vectors = 0, miscompares = 0;
    logic [15:0] last_rd = '0;

    always #5 clk = ~clk;

    muxbus_cycle u_muxbus_cycle (.*);

    task automatic chk(input string what, input logic [31:0] act, input logic [31:0] exp);
        vectors++;
        if (act !== exp) begin
            miscompares++;
            $display("FAIL %s: actual %0h expected %0h", what, act, exp);
        end
    endtask

    task automatic check_idle(input string tag);
        chk({tag, " R1 busy"}, busy, 0);
        chk({tag, " R1 done"}, done, 0);
        chk({tag, " R1 strobes"}, {rd_stb_n, wr_stb_n, xcvr_en_n, hi_sel_n}, 4'hF);
        chk({tag, " R1 latch/oe/io/dir"}, {addr_strobe, bus_ad_oe, io_sel, xfer_dir}, 0);
    endtask

    task automatic check_data_ph(input string tag, input logic w, input logic [3:0] st, input logic [15:0] wd, input logic io);
        chk({tag, " R7 R8 strobes"}, {rd_stb_n, wr_stb_n, xcvr_en_n}, {w, !w, 1'b0});
        chk({tag, " R7 R8 dir"}, xfer_dir, w);
        chk({tag, " R4 status"}, bus_hi, st);
        chk({tag, " R5 s7"}, hi_sel_n, 0);
        chk({tag, " R6 io"}, io_sel, io);
        chk({tag, " R3 latch off"}, addr_strobe, 0);
        chk({tag, " R7 R8 oe"}, bus_ad_oe, w);
        if (w) chk({tag, " R8 wdata"}, bus_ad_out, wd);
    endtask

    task automatic do_cycle(input string tag, input logic w, input logic io, input logic [19:0] a,
                            input logic word, input logic [1:0] seg, input logic ie,
                            input logic [15:0] wd, input logic [15:0] rv, input int nwait, input logic spam);
        logic [3:0] st;
        st = {1'b0, ie, seg};
        @(negedge clk);
        req_valid = 1; req_write = w; req_io = io; req_addr = a; req_word = word;
        req_seg = seg; req_ie = ie; req_wdata = wd; ready = 1; bus_ad_in = rv;
        @(negedge clk);                       // T1
        req_valid = 0;
        chk({tag, " R2 busy in T1"}, busy, 1);
        chk({tag, " R3 latch"}, addr_strobe, 1);
        chk({tag, " R3 low addr"}, {bus_ad_oe, bus_ad_out}, {1'b1, a[15:0]});
        chk({tag, " R3 high addr"}, bus_hi, a[19:16]);
        chk({tag, " R5 hi sel"}, hi_sel_n, !(word || a[0]));
        chk({tag, " R6 io T1"}, io_sel, io);
        chk({tag, " R7 R8 dir T1"}, xfer_dir, w);
        @(negedge clk);                       // T2
        check_data_ph({tag, " T2"}, w, st, wd, io);
        if (spam) begin
            req_valid = 1; req_addr = 20'h5A5A5; req_write = !w; req_io = !io; req_wdata = 16'hDEAD;
        end
        @(negedge clk);                       // T3
        check_data_ph({tag, " T3 R2"}, w, st, wd, io);
        req_valid = 0;
        ready = (nwait == 0);
        if (!w && nwait > 0) bus_ad_in = ~rv;  // must not be sampled here
        for (int i = 0; i < nwait; i++) begin
            @(negedge clk);                   // wait state
            check_data_ph({tag, " R9 wait"}, w, st, wd, io);
            ready = (i == nwait - 1);
            if (!w && i == nwait - 1) bus_ad_in = rv;
        end
        @(negedge clk);                       // T4
        ready = 1;
        chk({tag, " R11 done"}, done, 1);
        chk({tag, " R11 quiet"}, {rd_stb_n, wr_stb_n, xcvr_en_n}, 3'b111);
        chk({tag, " R6 io T4"}, io_sel, io);
        if (w) begin
            chk({tag, " R8 wdata T4"}, {bus_ad_oe, bus_ad_out}, {1'b1, wd});
            chk({tag, " R10 rdata held"}, rdata, last_rd);
        end else begin
            chk({tag, " R10 rdata"}, rdata, rv);
            last_rd = rv;
        end
        @(negedge clk);                       // idle
        check_idle({tag, " R11 after"});
        if (spam) begin
            @(negedge clk);
            chk({tag, " R2 no restart"}, {busy, addr_strobe}, 0);
        end
    endtask

    initial begin
        #2_000_000;
        miscompares++;
        $display("FAIL watchdog: actual hung expected finish");
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 0;
        @(negedge clk);
        check_idle("reset");
        chk("R1 rdata reset", rdata, 0);
        do_cycle("mem read word",  0, 0, 20'h30122, 1, 2'b10, 0, 16'h0,    16'h1234, 0, 0);
        do_cycle("io write odd",   1, 1, 20'h00061, 0, 2'b10, 1, 16'hAB00, 16'h0,    0, 0);
        do_cycle("mem byte even",  0, 0, 20'h6FFE0, 0, 2'b01, 1, 16'h0,    16'h00C3, 1, 0);
        do_cycle("mem write wait", 1, 0, 20'hF0002, 1, 2'b11, 0, 16'hBEEF, 16'h0,    3, 0);
        do_cycle("io read wait",   0, 1, 20'h003F8, 0, 2'b00, 1, 16'h0,    16'h7E81, 3, 0);
        do_cycle("busy ignore",    0, 0, 20'hA5A54, 1, 2'b11, 1, 16'h0,    16'h4242, 1, 1);
        $display("== %0d vectors applied, %0d miscompares ==", vectors, miscompares);
        $finish;
    end
endmodule